// File: doc/BRIEF.md
# I2C Target Controller with 7-bit and 10-bit Addressing

This block is the target side of an I2C bus. It watches the sampled SCL and SDA lines for start, repeated-start and stop conditions. After a start it shifts in the address byte and compares it with a programmable own address. It can also accept the general call address when that is enabled. The comparison works in either 7-bit mode or 10-bit mode. Once addressed, the block receives or transmits whole bytes. It pulls SDA low for acknowledges and outgoing zero bits, and it pulls SCL low to stretch the clock while it waits for the host.

The host interface works like a register port. The host watches three flags: an event flag, an address-matched flag and a byte-done flag. It services each event in two steps. First it pulses a status-read strobe. Then, after a received byte or in transmit mode, it pulses a data-read strobe or a data-write strobe (with the byte to send). SCL stays low until the step the current event needs has been done. The interrupt output follows the event flag, gated by the interrupt enable.

Top module: `i2c_target_top`

## Requirements
- R1: A start condition is SDA falling while SCL is high. After it, eight bits are sampled on SCL rising edges, MSB first. In 7-bit mode, an address byte whose upper seven bits equal `ownAddr[6:0]` is a match. A byte that does not match gets no acknowledge and sets no flag, and the block ignores the bus until the next start.
- R2: The byte 0x00 is a match in either mode only when `genCallEn` is 1. It puts the block in receive mode.
- R3: In 7-bit mode, bit 0 of the matched address byte sets the direction: 1 gives transmit mode (`txMode`=1) and 0 gives receive mode.
- R4: In 10-bit mode, the first byte must equal 11110 followed by `ownAddr[9:8]` and a 0. That header is acknowledged without setting any flag or stretching SCL. The next byte must equal `ownAddr[7:0]`; a match leaves the block in receive mode. A mismatch on either byte is ignored as in R1.
- R5: In 10-bit mode, the header with bit 0 set is a match only after the full 10-bit address has matched earlier in the same transfer, which happens when a repeated start follows it. It then enters transmit mode. Outside that case the header with bit 0 set is not acknowledged.
- R6: On an address match the block pulls SDA low during the ninth clock only if `ackEn` is 1. At the end of that clock it sets `eventFlag` and `addrMatchFlag`. `intReq` equals `eventFlag` when `intEn` is 1 and is 0 otherwise.
- R7: After a matched address phase in receive mode, SCL is held low until a `statusRd` pulse.
- R8: In receive mode, each received byte appears on `rdData` and is acknowledged only if `ackEn` is 1. `eventFlag` and `byteDoneFlag` are set, and SCL is held low until a `statusRd` followed by a `dataRd`. A `dataRd` without an earlier `statusRd` does not release SCL.
- R9: In transmit mode, SCL is held low until a `statusRd` followed by a `dataWr`. The written byte is sent MSB first. When the master acknowledges it, `eventFlag` and `byteDoneFlag` are set and SCL is held low again.
- R10: A master NACK (SDA high on the ninth clock) in transmit mode ends the transfer: SDA and SCL are released, no flag is set, and the bus is ignored until the next start or stop.
- R11: A stop condition (SDA rising while SCL is high) returns the block to idle, releases both lines and clears all three flags. After reset both lines are released and all flags are 0.
- R12: The step that releases a stretched SCL also clears `eventFlag` and `byteDoneFlag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rstN | input | 1 | Asynchronous reset, active low |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| sclDriveLow | output | 1 | 1 pulls SCL low (clock stretch) |
| sdaDriveLow | output | 1 | 1 pulls SDA low |
| ownAddr | input | 10 | Own address; the low 7 bits are used in 7-bit mode |
| tenBitMode | input | 1 | 1 selects 10-bit addressing |
| genCallEn | input | 1 | 1 accepts the general call address |
| ackEn | input | 1 | 1 lets the block acknowledge addresses and received bytes |
| intEn | input | 1 | Interrupt enable |
| statusRd | input | 1 | Host status-read strobe |
| dataRd | input | 1 | Host data-read strobe |
| dataWr | input | 1 | Host data-write strobe |
| wrData | input | 8 | Byte to transmit, taken on `dataWr` |
| rdData | output | 8 | Last received byte |
| eventFlag | output | 1 | An event is waiting for service |
| addrMatchFlag | output | 1 | Address matched in this transfer |
| byteDoneFlag | output | 1 | A data byte has completed |
| txMode | output | 1 | 1 in transmit mode |
| intReq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the 10-bit read entry. The block has to remember that the full two-byte address matched, across a repeated start, and accept the read header only then. The stimulus sends header, low address byte, service, repeated start and read header in one transfer. It then checks, in a separate transfer opened after a stop, that the same read header on its own is refused. Clock stretching is reached by having the bench master block on the SCL line level until the host strobes arrive, so each hold and each out-of-order strobe is seen at the pins.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 10;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam int SUB_W  = ADDR_W - BYTE_W;
  localparam int TAG_W  = BYTE_W - 1 - SUB_W;
  localparam logic [TAG_W-1:0] HDR_TAG = {{(TAG_W-1){1'b1}}, 1'b0};

  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_HOLD, S_TXSET, S_TX, S_TXACK, S_SKIP
  } stateT;

  typedef enum logic [1:0] {PH_ADDR1, PH_ADDR2, PH_DATA} phaseT;

  typedef enum logic [1:0] {K_ADDR, K_RX, K_TX} waitT;

  typedef struct packed {
    logic clrCnt;
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic latchRx;
    logic sampleAck;
  } dpCtlT;
endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpCtlT             ctl,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [ADDR_W-1:0] ownAddr,
  output logic              sclRise,
  output logic              sclFall,
  output logic              startDet,
  output logic              stopDet,
  output logic [CNT_W-1:0]  bitCnt,
  output logic              dirBit,
  output logic              txBit,
  output logic              ackIn,
  output logic [BYTE_W-1:0] rdData,
  output logic              addr7Hit,
  output logic              hdrHit,
  output logic              lowHit,
  output logic              gcHit
);
  logic              sclQ, sdaQ;
  logic [BYTE_W-1:0] shReg, rdReg;
  logic [CNT_W-1:0]  cnt;
  logic              ackReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ <= 1'b1;
      sdaQ <= 1'b1;
    end else begin
      sclQ <= sclIn;
      sdaQ <= sdaIn;
    end
  end

  assign sclRise  = sclIn & ~sclQ;
  assign sclFall  = ~sclIn & sclQ;
  assign startDet = sclIn & sclQ & sdaQ & ~sdaIn;
  assign stopDet  = sclIn & sclQ & ~sdaQ & sdaIn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.clrCnt) begin
      cnt <= '0;
    end else if (ctl.shiftIn || ctl.shiftOut) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg  <= '0;
      rdReg  <= '0;
      ackReg <= 1'b1;
    end else begin
      if (ctl.loadTx) begin
        shReg <= wrData;
      end else if (ctl.shiftIn) begin
        shReg <= {shReg[BYTE_W-2:0], sdaIn};
      end else if (ctl.shiftOut) begin
        shReg <= {shReg[BYTE_W-2:0], 1'b1};
      end
      if (ctl.latchRx) rdReg <= shReg;
      if (ctl.sampleAck) ackReg <= sdaIn;
    end
  end

  assign bitCnt   = cnt;
  assign dirBit   = shReg[0];
  assign txBit    = shReg[BYTE_W-1];
  assign ackIn    = ackReg;
  assign rdData   = rdReg;
  assign addr7Hit = (shReg[BYTE_W-1:1] == ownAddr[BYTE_W-2:0]);
  assign hdrHit   = (shReg[BYTE_W-1 -: TAG_W] == HDR_TAG) &&
                    (shReg[SUB_W:1] == ownAddr[ADDR_W-1 -: SUB_W]);
  assign lowHit   = (shReg == ownAddr[BYTE_W-1:0]);
  assign gcHit    = (shReg == '0);

  // R1: the bit counter never runs past one full byte
  a_r1_cnt_bound: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= CNT_W'(BYTE_W));
endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sclRise,
  input  logic             sclFall,
  input  logic             startDet,
  input  logic             stopDet,
  input  logic [CNT_W-1:0] bitCnt,
  input  logic             dirBit,
  input  logic             txBit,
  input  logic             ackIn,
  input  logic             addr7Hit,
  input  logic             hdrHit,
  input  logic             lowHit,
  input  logic             gcHit,
  input  logic             tenBitMode,
  input  logic             genCallEn,
  input  logic             ackEn,
  input  logic             intEn,
  input  logic             statusRd,
  input  logic             dataRd,
  input  logic             dataWr,
  output dpCtlT            ctl,
  output logic             sclDriveLow,
  output logic             sdaDriveLow,
  output logic             eventFlag,
  output logic             addrMatchFlag,
  output logic             byteDoneFlag,
  output logic             txMode,
  output logic             intReq
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  stateT state;
  phaseT phase;
  waitT  waitKind, hitKind;
  logic  goAddr2, ackDrive, tenSeen, statusSeen, txModeR;
  logic  evf, adsl, btf;
  logic  addrHit, hitTx, hitToAddr2, byteEnd, holdDone;

  assign byteEnd = (state == S_RX) && sclFall && (bitCnt == CNT_FULL);

  always_comb begin
    addrHit    = 1'b0;
    hitTx      = 1'b0;
    hitToAddr2 = 1'b0;
    hitKind    = K_ADDR;
    case (phase)
      PH_ADDR1: begin
        if (genCallEn && gcHit) begin
          addrHit = 1'b1;
        end else if (!tenBitMode) begin
          if (addr7Hit) begin
            addrHit = 1'b1;
            hitTx   = dirBit;
            hitKind = dirBit ? K_TX : K_ADDR;
          end
        end else if (hdrHit && !dirBit) begin
          addrHit    = 1'b1;
          hitToAddr2 = 1'b1;
        end else if (hdrHit && dirBit && tenSeen) begin
          addrHit = 1'b1;
          hitTx   = 1'b1;
          hitKind = K_TX;
        end
      end
      PH_ADDR2: addrHit = lowHit;
      default: begin
        addrHit = 1'b1;
        hitKind = K_RX;
      end
    endcase
  end

  always_comb begin
    case (waitKind)
      K_ADDR:  holdDone = statusSeen;
      K_RX:    holdDone = statusSeen && dataRd;
      default: holdDone = statusSeen && dataWr;
    endcase
    holdDone = holdDone && (state == S_HOLD);
  end

  always_comb begin
    ctl           = '0;
    ctl.clrCnt    = startDet || ((state == S_ACK) && sclFall) || holdDone;
    ctl.shiftIn   = (state == S_RX) && sclRise && (bitCnt < CNT_FULL);
    ctl.shiftOut  = (state == S_TX) && sclFall;
    ctl.loadTx    = holdDone && (waitKind == K_TX);
    ctl.latchRx   = byteEnd && (phase == PH_DATA);
    ctl.sampleAck = (state == S_TXACK) && sclRise;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      phase      <= PH_ADDR1;
      waitKind   <= K_ADDR;
      goAddr2    <= 1'b0;
      ackDrive   <= 1'b0;
      tenSeen    <= 1'b0;
      statusSeen <= 1'b0;
      txModeR    <= 1'b0;
      evf        <= 1'b0;
      adsl       <= 1'b0;
      btf        <= 1'b0;
    end else if (stopDet) begin
      state    <= S_IDLE;
      adsl     <= 1'b0;
      evf      <= 1'b0;
      btf      <= 1'b0;
      tenSeen  <= 1'b0;
      txModeR  <= 1'b0;
      ackDrive <= 1'b0;
    end else if (startDet) begin
      state    <= S_RX;
      phase    <= PH_ADDR1;
      txModeR  <= 1'b0;
      ackDrive <= 1'b0;
    end else begin
      case (state)
        S_RX: begin
          if (byteEnd) begin
            if (addrHit) begin
              state    <= S_ACK;
              ackDrive <= ackEn;
              goAddr2  <= hitToAddr2;
              waitKind <= hitKind;
              if (phase == PH_ADDR2) tenSeen <= 1'b1;
              if (hitTx) txModeR <= 1'b1;
            end else begin
              state   <= S_SKIP;
              tenSeen <= 1'b0;
            end
          end
        end
        S_ACK: begin
          if (sclFall) begin
            ackDrive <= 1'b0;
            if (goAddr2) begin
              state <= S_RX;
              phase <= PH_ADDR2;
            end else begin
              state      <= S_HOLD;
              evf        <= 1'b1;
              statusSeen <= 1'b0;
              if (waitKind == K_RX) btf <= 1'b1;
              else adsl <= 1'b1;
            end
          end
        end
        S_HOLD: begin
          if (statusRd) statusSeen <= 1'b1;
          if (holdDone) begin
            evf        <= 1'b0;
            btf        <= 1'b0;
            statusSeen <= 1'b0;
            if (waitKind == K_TX) begin
              state <= S_TXSET;
            end else begin
              state <= S_RX;
              phase <= PH_DATA;
            end
          end
        end
        S_TXSET: state <= S_TX;
        S_TX: begin
          if (sclFall && (bitCnt == CNT_LAST)) state <= S_TXACK;
        end
        S_TXACK: begin
          if (sclFall) begin
            if (!ackIn) begin
              state      <= S_HOLD;
              evf        <= 1'b1;
              btf        <= 1'b1;
              waitKind   <= K_TX;
              statusSeen <= 1'b0;
            end else begin
              state <= S_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sclDriveLow   = (state == S_HOLD) || (state == S_TXSET);
  assign sdaDriveLow   = ((state == S_ACK) && ackDrive) ||
                         (((state == S_TX) || (state == S_TXSET)) && !txBit);
  assign eventFlag     = evf;
  assign addrMatchFlag = adsl;
  assign byteDoneFlag  = btf;
  assign txMode        = txModeR;
  assign intReq        = evf && intEn;

  // R7: a stretched clock always has a pending event behind it
  a_r7_hold_has_event: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD) |-> evf);

  // R11: a stop leaves the address flag clear and SCL free
  a_r11_stop_clears: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (!adsl && !sclDriveLow));

  // R10: SDA is only changed by the block while SCL is low
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclIn);

  // R6: the address flag rises only at the end of an acknowledge clock
  a_r6_adsl_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adsl) |-> $past(state == S_ACK));

  // R9: bits go out only in transmit mode
  a_r9_tx_needs_mode: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_TX) |-> txModeR);
endmodule

// File: rtl/i2c_target_top.sv
module i2c_target_top
  import i2cs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclDriveLow,
  output logic              sdaDriveLow,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              tenBitMode,
  input  logic              genCallEn,
  input  logic              ackEn,
  input  logic              intEn,
  input  logic              statusRd,
  input  logic              dataRd,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] rdData,
  output logic              eventFlag,
  output logic              addrMatchFlag,
  output logic              byteDoneFlag,
  output logic              txMode,
  output logic              intReq
);
  dpCtlT            ctl;
  logic             sclRise, sclFall, startDet, stopDet;
  logic [CNT_W-1:0] bitCnt;
  logic             dirBit, txBit, ackIn;
  logic             addr7Hit, hdrHit, lowHit, gcHit;

  i2cs_datapath dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .ctl      (ctl),
    .wrData   (wrData),
    .ownAddr  (ownAddr),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .bitCnt   (bitCnt),
    .dirBit   (dirBit),
    .txBit    (txBit),
    .ackIn    (ackIn),
    .rdData   (rdData),
    .addr7Hit (addr7Hit),
    .hdrHit   (hdrHit),
    .lowHit   (lowHit),
    .gcHit    (gcHit)
  );

  i2cs_ctrl ctrl_i (
    .clk           (clk),
    .rstN          (rstN),
    .sclIn         (sclIn),
    .sclRise       (sclRise),
    .sclFall       (sclFall),
    .startDet      (startDet),
    .stopDet       (stopDet),
    .bitCnt        (bitCnt),
    .dirBit        (dirBit),
    .txBit         (txBit),
    .ackIn         (ackIn),
    .addr7Hit      (addr7Hit),
    .hdrHit        (hdrHit),
    .lowHit        (lowHit),
    .gcHit         (gcHit),
    .tenBitMode    (tenBitMode),
    .genCallEn     (genCallEn),
    .ackEn         (ackEn),
    .intEn         (intEn),
    .statusRd      (statusRd),
    .dataRd        (dataRd),
    .dataWr        (dataWr),
    .ctl           (ctl),
    .sclDriveLow   (sclDriveLow),
    .sdaDriveLow   (sdaDriveLow),
    .eventFlag     (eventFlag),
    .addrMatchFlag (addrMatchFlag),
    .byteDoneFlag  (byteDoneFlag),
    .txMode        (txMode),
    .intReq        (intReq)
  );
endmodule

// File: tb/i2c_target_top_tb_top.sv
module i2c_target_top_tb_top;
  localparam int Q = 4;
  // {address byte, genCallEn, ackEn, expected ack, expected match, expected tx}
  localparam logic [12:0] VEC [0:6] = '{
    {8'h6A, 5'b01110},
    {8'h6B, 5'b01111},
    {8'h6C, 5'b01000},
    {8'h00, 5'b11110},
    {8'h00, 5'b01000},
    {8'h6A, 5'b00010},
    {8'hF4, 5'b01000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sclLine, sdaLine, sclDriveLow, sdaDriveLow;
  logic [9:0] ownAddr = 10'h2B5;
  logic tenBitMode = 1'b0, genCallEn = 1'b0, ackEn = 1'b1, intEn = 1'b0;
  logic statusRd = 1'b0, dataRd = 1'b0, dataWr = 1'b0;
  logic [7:0] wrData = 8'h00, rdData;
  logic eventFlag, addrMatchFlag, byteDoneFlag, txMode, intReq;
  int checks = 0, fails = 0;
  logic acked;
  logic [7:0] rb;

  always #5 clk = ~clk;

  assign sclLine = mScl & ~sclDriveLow;
  assign sdaLine = mSda & ~sdaDriveLow;

  i2c_target_top dut_i (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow),
    .ownAddr(ownAddr), .tenBitMode(tenBitMode), .genCallEn(genCallEn),
    .ackEn(ackEn), .intEn(intEn), .statusRd(statusRd), .dataRd(dataRd),
    .dataWr(dataWr), .wrData(wrData), .rdData(rdData),
    .eventFlag(eventFlag), .addrMatchFlag(addrMatchFlag),
    .byteDoneFlag(byteDoneFlag), .txMode(txMode), .intReq(intReq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mStart();
    mSda = 1'b1; mScl = 1'b1; waitCyc(Q);
    mSda = 1'b0; waitCyc(Q);
    mScl = 1'b0; waitCyc(Q);
  endtask

  task automatic mRestart();
    mSda = 1'b1; waitCyc(Q);
    mScl = 1'b1;
    @(negedge clk);
    while (!sclLine) @(negedge clk);
    waitCyc(Q);
    mSda = 1'b0; waitCyc(Q);
    mScl = 1'b0; waitCyc(Q);
  endtask

  task automatic mStop();
    mSda = 1'b0; waitCyc(Q);
    mScl = 1'b1;
    @(negedge clk);
    while (!sclLine) @(negedge clk);
    waitCyc(Q);
    mSda = 1'b1; waitCyc(Q);
  endtask

  task automatic mClock(input logic bitOut, output logic bitIn);
    mSda = bitOut; waitCyc(Q);
    mScl = 1'b1;
    @(negedge clk);
    while (!sclLine) @(negedge clk);
    waitCyc(Q);
    bitIn = sdaLine;
    waitCyc(Q);
    mScl = 1'b0; waitCyc(Q);
  endtask

  task automatic mWriteByte(input logic [7:0] b, output logic ack);
    logic d;
    for (int i = 7; i >= 0; i--) mClock(b[i], d);
    mClock(1'b1, d);
    ack = ~d;
  endtask

  task automatic mReadByte(input logic nack, output logic [7:0] b);
    logic d;
    for (int i = 7; i >= 0; i--) begin
      mClock(1'b1, d);
      b[i] = d;
    end
    mClock(nack, d);
  endtask

  task automatic hostStatus();
    @(negedge clk) statusRd = 1'b1;
    @(negedge clk) statusRd = 1'b0;
  endtask

  task automatic hostRead();
    @(negedge clk) dataRd = 1'b1;
    @(negedge clk) dataRd = 1'b0;
  endtask

  task automatic hostWrite(input logic [7:0] b);
    @(negedge clk) begin dataWr = 1'b1; wrData = b; end
    @(negedge clk) dataWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    waitCyc(5);
    rstN = 1'b1;
    waitCyc(3);
    // R11 reset state
    chk("R11 reset scl", {15'd0, sclDriveLow}, 16'd0);
    chk("R11 reset sda", {15'd0, sdaDriveLow}, 16'd0);
    chk("R11 reset flags", {13'd0, eventFlag, addrMatchFlag, byteDoneFlag}, 16'd0);

    // 7-bit address table
    for (int i = 0; i < 7; i++) begin
      logic [12:0] v;
      v = VEC[i];
      genCallEn = v[4];
      ackEn = v[3];
      tenBitMode = 1'b0;
      intEn = 1'b0;
      mStart();
      mWriteByte(v[12:5], acked);
      waitCyc(2);
      chk("R1 R2 address ack", {15'd0, acked}, {15'd0, v[2]});
      chk("R6 match flag", {15'd0, addrMatchFlag}, {15'd0, v[1]});
      chk("R7 stretch after match", {15'd0, sclDriveLow}, {15'd0, v[1]});
      chk("R6 intReq masked", {15'd0, intReq}, 16'd0);
      if (v[1]) begin
        chk("R3 direction", {15'd0, txMode}, {15'd0, v[0]});
        hostStatus();
        if (v[0]) hostWrite(8'hFF);
      end
      mStop();
      waitCyc(2);
      chk("R11 stop clears match", {15'd0, addrMatchFlag}, 16'd0);
    end

    // receive path
    ackEn = 1'b1; genCallEn = 1'b0; intEn = 1'b1;
    mStart();
    mWriteByte(8'h6A, acked);
    waitCyc(2);
    chk("R6 intReq raised", {15'd0, intReq}, 16'd1);
    hostStatus();
    waitCyc(2);
    chk("R7 released by status", {15'd0, sclDriveLow}, 16'd0);
    chk("R12 event cleared", {15'd0, eventFlag}, 16'd0);
    mWriteByte(8'hC3, acked);
    waitCyc(2);
    chk("R8 data ack", {15'd0, acked}, 16'd1);
    chk("R8 event+byte flags", {14'd0, eventFlag, byteDoneFlag}, 16'd3);
    chk("R8 rdData", {8'd0, rdData}, 16'h00C3);
    chk("R8 held", {15'd0, sclDriveLow}, 16'd1);
    hostRead();
    waitCyc(3);
    chk("R8 read before status ignored", {15'd0, sclDriveLow}, 16'd1);
    hostStatus();
    hostRead();
    waitCyc(2);
    chk("R8 released", {15'd0, sclDriveLow}, 16'd0);
    chk("R12 flags cleared", {14'd0, eventFlag, byteDoneFlag}, 16'd0);
    ackEn = 1'b0;
    mWriteByte(8'h5E, acked);
    waitCyc(2);
    chk("R8 no ack when disabled", {15'd0, acked}, 16'd0);
    chk("R8 rdData second", {8'd0, rdData}, 16'h005E);
    chk("R8 event set", {15'd0, eventFlag}, 16'd1);
    hostStatus();
    hostRead();
    mStop();
    ackEn = 1'b1; intEn = 1'b0;

    // transmit path
    mStart();
    mWriteByte(8'h6B, acked);
    waitCyc(2);
    chk("R3 tx mode", {15'd0, txMode}, 16'd1);
    hostStatus();
    waitCyc(3);
    chk("R9 held until write", {15'd0, sclDriveLow}, 16'd1);
    hostWrite(8'h96);
    mReadByte(1'b0, rb);
    waitCyc(2);
    chk("R9 byte out", {8'd0, rb}, 16'h0096);
    chk("R9 flags after master ack", {14'd0, eventFlag, byteDoneFlag}, 16'd3);
    chk("R9 held again", {15'd0, sclDriveLow}, 16'd1);
    hostStatus();
    hostWrite(8'h5A);
    mReadByte(1'b1, rb);
    waitCyc(2);
    chk("R9 second byte", {8'd0, rb}, 16'h005A);
    chk("R10 lines free after nack", {14'd0, sclDriveLow, sdaDriveLow}, 16'd0);
    chk("R10 no event", {15'd0, eventFlag}, 16'd0);
    mStop();

    // 10-bit: write then repeated-start read
    tenBitMode = 1'b1;
    mStart();
    mWriteByte(8'hF4, acked);
    waitCyc(2);
    chk("R4 header ack", {15'd0, acked}, 16'd1);
    chk("R4 header no flag no stretch", {14'd0, eventFlag, sclDriveLow}, 16'd0);
    mWriteByte(8'hB5, acked);
    waitCyc(2);
    chk("R4 low byte ack", {15'd0, acked}, 16'd1);
    chk("R4 match rx", {14'd0, addrMatchFlag, txMode}, 16'd2);
    hostStatus();
    mRestart();
    mWriteByte(8'hF5, acked);
    waitCyc(2);
    chk("R5 read header ack", {15'd0, acked}, 16'd1);
    chk("R5 tx entered", {14'd0, addrMatchFlag, txMode}, 16'd3);
    hostStatus();
    hostWrite(8'h3C);
    mReadByte(1'b1, rb);
    chk("R5 byte out", {8'd0, rb}, 16'h003C);
    mStop();

    // 10-bit refusals
    mStart();
    mWriteByte(8'hF5, acked);
    chk("R5 read header alone refused", {15'd0, acked}, 16'd0);
    mStop();
    mStart();
    mWriteByte(8'hF2, acked);
    chk("R4 wrong header", {15'd0, acked}, 16'd0);
    mStop();
    mStart();
    mWriteByte(8'hF4, acked);
    mWriteByte(8'hB4, acked);
    waitCyc(2);
    chk("R4 wrong low byte", {15'd0, acked}, 16'd0);
    chk("R4 no match flag", {15'd0, addrMatchFlag}, 16'd0);
    mStop();

    waitCyc(4);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule